// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block turns the system clock into a clock-enable pulse for serial transmit and receive logic. The pulse rate is sixteen times the serial bit rate. The divide ratio is a 16-bit divisor kept in two byte-wide latches. The divisor is the input clock frequency divided by sixteen times the wanted bit rate. For example, an input clock of 1.8432 MHz and a divisor of 96 give 19200 pulses per second, which suits 1200 baud. The divisor may be any value from 1 to 65535.

Software loads the divisor one byte at a time through a plain write strobe, with a select bit that chooses the byte. Every write, to either byte, reloads the internal down-counter at once with the full new divisor. A new rate therefore starts on the next cycle, and no long count left over from the old divisor has to run out first. A divisor of zero stops the output. After reset the divisor is zero, so the output stays low until software programs a rate.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both divisor bytes are 0, and `tick` stays low until a nonzero divisor is written.
- R2: A write with `wr_sel`=0 places `wr_data` in divisor bits 7..0, and a write with `wr_sel`=1 places it in bits 15..8.
- R3: With a nonzero divisor D and no writes, `tick` is high on exactly one cycle out of every D consecutive cycles.
- R4: For D of 2 or more, `tick` is never high on two consecutive cycles unless a write intervenes.
- R5: With D = 1, `tick` is high on every cycle.
- R6: With D = 0, `tick` stays low.
- R7: A write clocked at edge t reloads the counter with the full updated divisor D. The first following `tick` is the cycle that begins at edge t+D-1, whatever count was in progress.
- R8: A write to one byte leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| wr_sel | input | 1 | Byte select: 0 low byte, 1 high byte |
| wr_data | input | 8 | Byte to write |
| tick | output | 1 | One-cycle enable at 16x the bit rate |

## Verification
The bench targets these corner cases:
- Divisor 1. A counter that passes through an idle state would give a tick only on alternate cycles, or none at all.
- Divisor 0. A counter that wraps would tick every 65536 cycles.
- Divisor 2. An off-by-one reload would give back-to-back ticks, or a period of 3.
- A rewrite in the middle of a long count. A design that only picks up the new value at the next reload would keep the old gap, so the next tick would be late.
- Writes to the high byte alone, checked with a low byte already loaded. A design that clears or shifts the other byte would give the wrong period.

## Simulation Flow
The `tick` output is sampled every cycle and compared with a cycle count derived from the requirements. The stimulus is fixed-seed random rewrites at random points, mixed with directed cases.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 2;
  localparam int DIV_W     = BYTE_W * NUM_BYTES;
endpackage

// File: rtl/btg_byte_latch.sv
// One byte of the divisor. Also presents the value the byte will hold
// after the current edge, so the counter can reload with the full new divisor.
module btg_byte_latch #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 1,
  parameter int INDEX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] q,
  output logic [BYTE_W-1:0] q_next
);
  logic hit;

  assign hit    = wr_en && (wr_sel == SEL_W'(INDEX));
  assign q_next = hit ? wr_data : q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/btg_down_counter.sv
// Reloadable down-counter. tick is high while the count equals one.
module btg_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;   // any write restarts at once
    else if (tick)      cnt <= period;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W    = btg_pkg::BYTE_W,
  parameter int NUM_BYTES = btg_pkg::NUM_BYTES
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [((NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1)-1:0] wr_sel,
  input  logic [BYTE_W-1:0]                             wr_data,
  output logic                                          tick
);
  localparam int DIV_W = BYTE_W * NUM_BYTES;
  localparam int SEL_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [DIV_W-1:0] div_cur;
  logic [DIV_W-1:0] div_next;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    btg_byte_latch #(
      .BYTE_W(BYTE_W),
      .SEL_W (SEL_W),
      .INDEX (b)
    ) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .q      (div_cur[b*BYTE_W +: BYTE_W]),
      .q_next (div_next[b*BYTE_W +: BYTE_W])
    );
  end

  btg_down_counter #(.W(DIV_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_en),
    .load_val(div_next),
    .period  (div_cur),
    .tick    (tick)
  );
endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input logic                                          clk,
  input logic                                          rst_n,
  input logic                                          wr_en,
  input logic [((NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1)-1:0] wr_sel,
  input logic [BYTE_W-1:0]                             wr_data,
  input logic                                          tick
);
  localparam int DIV_W = BYTE_W * NUM_BYTES;

  // Divisor as seen from the write port, and cycles since the last reload.
  logic [DIV_W-1:0] shadow;
  logic [DIV_W:0]   since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      since  <= (DIV_W+1)'(1);
    end else begin
      if (wr_en) shadow[wr_sel*BYTE_W +: BYTE_W] <= wr_data;
      if (wr_en || tick)          since <= (DIV_W+1)'(1);
      else if (!(&since))         since <= since + (DIV_W+1)'(1);
    end
  end

  assert_idle_when_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow == '0) |-> !tick);

  assert_tick_at_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (since == {1'b0, shadow}));

  assert_no_missed_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow != '0) |-> (since <= {1'b0, shadow}));

  assert_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && shadow > DIV_W'(1)) |=> !tick);

  assert_every_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow == DIV_W'(1)) |-> tick);
endmodule

bind baud_tick_gen btg_checker #(
  .BYTE_W   (BYTE_W),
  .NUM_BYTES(NUM_BYTES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .tick   (tick)
);

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [0:0] wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick;

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";

  int mdiv  = 0;   // bench view of the divisor
  int phase = 1;   // cycle index since last reload, starting at 1

  baud_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick)
  );

  always #5 clk = ~clk;

  function automatic logic exp_tick(int d, int ph);
    return (d != 0) && (ph == d);
  endfunction

  function automatic int put_byte(int d, int sel, int data);
    if (sel == 0) return (d & 32'hFF00) | (data & 32'hFF);
    return (d & 32'h00FF) | ((data & 32'hFF) << 8);
  endfunction

  // One cycle: check the current tick, then drive the next inputs.
  task automatic step(input logic w, input int sel, input int data);
    logic e;
    @(negedge clk);
    e = exp_tick(mdiv, phase);
    vectors++;
    if (tick !== e) begin
      fails++;
      $display("FAIL %s: divisor %0d phase %0d tick=%b expected %b",
               cur_req, mdiv, phase, tick, e);
    end
    if (w) begin
      mdiv  = put_byte(mdiv, sel, data);
      phase = 1;
    end else if (e) phase = 1;
    else if (phase < 1000000) phase++;
    wr_en   = w;
    wr_sel  = 1'(sel);
    wr_data = 8'(data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0);
  endtask

  task automatic wr(input int sel, input int data);
    step(1'b1, sel, data);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1"; idle(40);              // reset: no tick
    cur_req = "R2"; wr(0, 3); idle(30);    // low byte alone -> period 3
    cur_req = "R8"; wr(1, 1); idle(600);   // high byte kept with low: 259
    cur_req = "R2"; wr(1, 0); wr(0, 96); idle(500);
    cur_req = "R4"; wr(0, 2); idle(50);
    cur_req = "R5"; wr(0, 1); idle(40);
    cur_req = "R6"; wr(0, 0); idle(300);
    cur_req = "R7"; wr(0, 200); idle(60); wr(0, 5); idle(30);
    wr(1, 2); idle(20); wr(1, 0); idle(40);  // mid-count high-byte rewrite
    cur_req = "R3";
    for (int k = 0; k < 40; k++) begin
      int sel;
      int data;
      sel  = int'($urandom % 2);
      data = (sel == 1) ? int'($urandom % 3) : int'($urandom % 256);
      wr(sel, data);
      idle(1 + int'($urandom % 150));
    end
    cur_req = "R5"; wr(1, 0); wr(0, 1); idle(10); wr(0, 1); idle(5);
    cur_req = "R6"; wr(0, 0); idle(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule